// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt events of a multi-channel DMA engine and turns them into one interrupt line for software. Every channel can raise four kinds of event: completion of a whole descriptor chain, completion of a single node within a chain, and two separate error classes. Each event arrives as a one-cycle pulse and is latched in a sticky raw bit. Each of the four classes has its own raw word, enable word and masked word, and each word holds one bit per channel.

Software reaches the block through a simple register port. Reads are combinational on the address. Writes take effect at the next clock edge. The enable words can be read and written. A raw bit is cleared by writing a one to its position. The masked words and the summary word can only be read. When a channel is torn down, software writes that channel's bit to all four raw words, which clears that channel and leaves the others alone. The interrupt output is registered. It follows whether any enabled event is pending anywhere.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, every raw and enable bit is zero, every register reads zero, and irq_o is low.
- R2: A pulse on channel i of an event input sets bit i of that class's raw word at the next edge, and the bit stays set until it is cleared. The raw words sit at 0x600 (chain end), 0x608 (node), 0x610 (error A) and 0x618 (error B).
- R3: The enable words at 0x018, 0x01C, 0x020 and 0x024 (same class order as R2) are written whole and read back. A 1 enables the channel. Bits at or above NUM_CH read as zero.
- R4: A write to a raw word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When an event and a write-one clear hit the same raw bit in the same cycle, the bit ends up set.
- R6: The masked words at 0x004, 0x008, 0x00C and 0x010 (same class order as R2) read as raw AND enable for their class.
- R7: The summary word at 0x000 has bit i set exactly when at least one of the four masked words has bit i set.
- R8: irq_o is registered. One cycle after any masked bit is pending it is high, and one cycle after none is pending it is low.
- R9: Reads of any address that is not a defined register return zero. Writes to the summary word, the masked words or undefined addresses change no state.
- R10: Writing the single channel bit 1<<i to all four raw words clears channel i in every class and leaves the other channels' pending bits in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_chain_i | input | NUM_CH | Chain-end completion pulses, one per channel |
| evt_node_i | input | NUM_CH | Per-node completion pulses |
| evt_err_a_i | input | NUM_CH | Error class A pulses |
| evt_err_b_i | input | NUM_CH | Error class B pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on the address |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The main function is first tried with single events on distinct channels and distinct classes while every enable bit is off. In that state the raw words fill but irq_o must stay low, which separates capture from masking. Partial enable patterns then show whether the masked and summary words pick the right class and channel. Targeted writes clear with zero bits, clear with one bits, and clear in the same cycle as an event on the same bit, which separates write-one-clear from plain overwrite and tests set priority. A long pseudo-random stream of sparse events mixed with writes to every address is then compared against a behavioural model on every cycle, so any stray write decode or read mux slip shows up.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
  localparam int NUM_CLASS = 4;
  localparam int CLS_W     = 2;

  // class index order: 0 chain end, 1 node, 2 error A, 3 error B
  localparam int SUM_OFS   = 'h000;
  localparam int PEND_BASE = 'h004;
  localparam int PEND_STEP = 4;
  localparam int EN_BASE   = 'h018;
  localparam int EN_STEP   = 4;
  localparam int RAW_BASE  = 'h600;
  localparam int RAW_STEP  = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SUM,
    RD_PEND,
    RD_EN,
    RD_RAW
  } rd_kind_e;

  function automatic int pend_ofs(int c);
    return PEND_BASE + c * PEND_STEP;
  endfunction

  function automatic int en_ofs(int c);
    return EN_BASE + c * EN_STEP;
  endfunction

  function automatic int raw_ofs(int c);
    return RAW_BASE + c * RAW_STEP;
  endfunction
endpackage

// File: rtl/dma_irq_decode.sv
`timescale 1ns/1ps
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [NUM_CLASS-1:0]    clr_sel_o,
  output logic [NUM_CLASS-1:0]    en_sel_o,
  output rd_kind_e                rd_kind_o,
  output logic [CLS_W-1:0]        rd_cls_o
);
  always_comb begin
    clr_sel_o = '0;
    en_sel_o  = '0;
    rd_kind_o = RD_NONE;
    rd_cls_o  = '0;
    if (addr_i == ADDR_W'(SUM_OFS)) rd_kind_o = RD_SUM;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (addr_i == ADDR_W'(pend_ofs(c))) begin
        rd_kind_o = RD_PEND;
        rd_cls_o  = CLS_W'(c);
      end
      if (addr_i == ADDR_W'(en_ofs(c))) begin
        rd_kind_o   = RD_EN;
        rd_cls_o    = CLS_W'(c);
        en_sel_o[c] = we_i;
      end
      if (addr_i == ADDR_W'(raw_ofs(c))) begin
        rd_kind_o    = RD_RAW;
        rd_cls_o     = CLS_W'(c);
        clr_sel_o[c] = we_i;
      end
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
`timescale 1ns/1ps
module dma_irq_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic              en_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] raw_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  // set has priority over write-one-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign pend_o = raw_q & en_q;
endmodule

// File: rtl/dma_irq_combine.sv
`timescale 1ns/1ps
module dma_irq_combine
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0]     pend_i,
  output logic [NUM_CH-1:0]                    summary_o,
  output logic                                 irq_o
);
  logic irq_q;

  always_comb begin
    summary_o = '0;
    for (int c = 0; c < NUM_CLASS; c++) summary_o |= pend_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |summary_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
`timescale 1ns/1ps
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_chain_i,
  input  logic [NUM_CH-1:0] evt_node_i,
  input  logic [NUM_CH-1:0] evt_err_a_i,
  input  logic [NUM_CH-1:0] evt_err_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_CLASS-1:0][NUM_CH-1:0] evt_vec, raw_vec, en_vec, pend_vec;
  logic [NUM_CLASS-1:0]             clr_sel, en_sel;
  logic [NUM_CH-1:0]                summary, wdata_lo;
  rd_kind_e                         rd_kind;
  logic [CLS_W-1:0]                 rd_cls;

  assign evt_vec  = {evt_err_b_i, evt_err_a_i, evt_node_i, evt_chain_i};
  assign wdata_lo = reg_wdata_i[NUM_CH-1:0];

  generate
    if (DATA_W > NUM_CH) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_CH];
    end
  endgenerate

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .clr_sel_o (clr_sel),
    .en_sel_o  (en_sel),
    .rd_kind_o (rd_kind),
    .rd_cls_o  (rd_cls)
  );

  generate
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_bank
      dma_irq_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (evt_vec[c]),
        .clr_we_i (clr_sel[c]),
        .en_we_i  (en_sel[c]),
        .wdata_i  (wdata_lo),
        .raw_o    (raw_vec[c]),
        .en_o     (en_vec[c]),
        .pend_o   (pend_vec[c])
      );
    end
  endgenerate

  dma_irq_combine #(.NUM_CH(NUM_CH)) u_combine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_vec),
    .summary_o (summary),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (rd_kind)
      RD_SUM:  reg_rdata_o[NUM_CH-1:0] = summary;
      RD_PEND: reg_rdata_o[NUM_CH-1:0] = pend_vec[rd_cls];
      RD_EN:   reg_rdata_o[NUM_CH-1:0] = en_vec[rd_cls];
      RD_RAW:  reg_rdata_o[NUM_CH-1:0] = raw_vec[rd_cls];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
`timescale 1ns/1ps
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             reg_we_i,
  input logic [ADDR_W-1:0]                reg_addr_i,
  input logic [NUM_CH-1:0]                wdata_lo_i,
  input logic                             irq_o,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] evt_vec_i,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] raw_vec_i,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] en_vec_i
);
  logic pend_any;
  assign pend_any = |(raw_vec_i & en_vec_i);

  // R8
  assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(pend_any)));

  generate
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(raw_ofs(c));
      localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(en_ofs(c));

      assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_vec_i[c]) |=> ((raw_vec_i[c] & $past(evt_vec_i[c])) == $past(evt_vec_i[c])));

      assert_raw_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(reg_we_i && reg_addr_i == A_RAW) && evt_vec_i[c] == '0) |=> $stable(raw_vec_i[c]));

      assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == A_RAW)
        |=> ((raw_vec_i[c] & $past(wdata_lo_i & ~evt_vec_i[c])) == '0));

      assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == A_RAW && |(wdata_lo_i & evt_vec_i[c]))
        |=> ((raw_vec_i[c] & $past(wdata_lo_i & evt_vec_i[c])) == $past(wdata_lo_i & evt_vec_i[c])));

      assert_en_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && reg_addr_i == A_EN) |=> $stable(en_vec_i[c]));
    end
  endgenerate
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wdata_lo_i (wdata_lo),
  .irq_o      (irq_o),
  .evt_vec_i  (evt_vec),
  .raw_vec_i  (raw_vec),
  .en_vec_i   (en_vec)
);

// File: tb/dma_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_irq_ctrl_bench;
  localparam int NCH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0][NCH-1:0] evt = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errs = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_irq_ctrl u_dma_irq_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_chain_i (evt[0]),
    .evt_node_i  (evt[1]),
    .evt_err_a_i (evt[2]),
    .evt_err_b_i (evt[3]),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference
  logic [15:0] m_raw [4];
  logic [15:0] m_en  [4];
  logic        m_irq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 4; c++) begin m_raw[c] = 0; m_en[c] = 0; end
      m_irq = 0;
    end else begin
      logic any;
      any = 0;
      for (int c = 0; c < 4; c++) if ((m_raw[c] & m_en[c]) != 0) any = 1;
      m_irq = any;
      for (int c = 0; c < 4; c++) begin
        logic [15:0] clr;
        clr = (we && addr == 12'h600 + 12'(8*c)) ? wdata[15:0] : 16'h0;
        m_raw[c] = (m_raw[c] & ~clr) | evt[c];
        if (we && addr == 12'h018 + 12'(4*c)) m_en[c] = wdata[15:0];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [15:0] s;
    s = 0;
    for (int c = 0; c < 4; c++) s |= m_raw[c] & m_en[c];
    if (a == 12'h000) return {16'h0, s};
    for (int c = 0; c < 4; c++) begin
      if (a == 12'h004 + 12'(4*c)) return {16'h0, m_raw[c] & m_en[c]};
      if (a == 12'h018 + 12'(4*c)) return {16'h0, m_en[c]};
      if (a == 12'h600 + 12'(8*c)) return {16'h0, m_raw[c]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h000) return "R7";
    if (a >= 12'h004 && a <= 12'h010 && a[1:0] == 0) return "R6";
    if (a >= 12'h018 && a <= 12'h024 && a[1:0] == 0) return "R3";
    if (a == 12'h600 || a == 12'h608 || a == 12'h610 || a == 12'h618) return "R2";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h (addr %h, t=%0t)", tag, act, exp_v, addr, $time);
    end
  endtask

  // compare against model, then drive next inputs
  task automatic tick(input logic [3:0][NCH-1:0] e, input logic w, input logic [11:0] a,
                      input logic [31:0] d);
    @(negedge clk_i);
    if (cmp_on) begin
      chk(tag_of(addr), rdata, exp_rd(addr));
      chk("R8", {31'h0, irq}, {31'h0, m_irq});
    end
    evt = e; we = w; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    tick('0, 1'b1, a, d);
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp_v, input string tag);
    tick('0, 1'b0, a, 32'h0);
    #5;
    chk(tag, rdata, exp_v);
  endtask

  task automatic expect_irq(input logic exp_v, input string tag);
    tick('0, 1'b0, 12'h000, 32'h0);
    #5;
    chk(tag, {31'h0, irq}, {31'h0, exp_v});
  endtask

  localparam logic [11:0] ADDRS [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
    12'h018, 12'h01C, 12'h020, 12'h024, 12'h600, 12'h608, 12'h610, 12'h618,
    12'h014, 12'h604, 12'h700};

  initial begin
    #(20 * 50000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [3:0][NCH-1:0] e;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", {31'h0, irq}, 32'h0);
    addr = 12'h600; #1; chk("R1", rdata, 32'h0);
    addr = 12'h018; #1; chk("R1", rdata, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    cmp_on = 1'b1;
    for (int i = 0; i < 9; i++) expect_rd(ADDRS[i], 32'h0, "R1");

    // R2: capture with all enables off; irq stays low (R8)
    e = '0; e[0] = 16'h0008; e[1] = 16'h0001; e[2] = 16'h8000; e[3] = 16'h0080;
    tick(e, 1'b0, 12'h000, 0);
    expect_rd(12'h600, 32'h0008, "R2");
    expect_rd(12'h608, 32'h0001, "R2");
    expect_rd(12'h610, 32'h8000, "R2");
    expect_rd(12'h618, 32'h0080, "R2");
    expect_rd(12'h004, 32'h0, "R6");
    expect_irq(1'b0, "R8");

    // enable chain class
    wr(12'h018, 32'h0000FFFF);
    expect_rd(12'h004, 32'h0008, "R6");
    expect_irq(1'b1, "R8");
    expect_rd(12'h000, 32'h0008, "R7");

    // partial enables
    wr(12'h01C, 32'h0001);
    wr(12'h020, 32'h0000);
    wr(12'h024, 32'h0080);
    expect_rd(12'h000, 32'h0089, "R7");
    expect_rd(12'h00C, 32'h0, "R6");
    expect_rd(12'h610, 32'h8000, "R2");

    // R3: upper bits not stored
    wr(12'h018, 32'hFFFFFFFF);
    expect_rd(12'h018, 32'h0000FFFF, "R3");

    // R4: zeros keep, ones clear
    wr(12'h600, 32'h0004);
    expect_rd(12'h600, 32'h0008, "R4");
    wr(12'h600, 32'h0008);
    expect_rd(12'h600, 32'h0, "R4");

    // R5: event beats clear on the same bit
    e = '0; e[0] = 16'h0004;
    tick(e, 1'b1, 12'h600, 32'h0004);
    expect_rd(12'h600, 32'h0004, "R5");

    // R9: read-only and undefined writes ignored, undefined reads zero
    wr(12'h000, 32'hFFFF);
    wr(12'h004, 32'hFFFF);
    wr(12'h014, 32'hFFFF);
    wr(12'h604, 32'hFFFF);
    expect_rd(12'h014, 32'h0, "R9");
    expect_rd(12'h604, 32'h0, "R9");
    expect_rd(12'h700, 32'h0, "R9");
    expect_rd(12'h600, 32'h0004, "R9");
    expect_rd(12'h618, 32'h0080, "R9");

    // R10: tear down channel 5, channel 6 stays
    for (int c = 0; c < 4; c++) wr(12'h600 + 12'(8*c), 32'hFFFF);
    e = '0; for (int c = 0; c < 4; c++) e[c] = 16'h0060;
    tick(e, 1'b0, 12'h000, 0);
    for (int c = 0; c < 4; c++) wr(12'h600 + 12'(8*c), 32'h0020);
    for (int c = 0; c < 4; c++) expect_rd(12'h600 + 12'(8*c), 32'h0040, "R10");

    // R8: irq falls once everything pending is cleared
    for (int c = 0; c < 4; c++) wr(12'h600 + 12'(8*c), 32'hFFFF);
    expect_irq(1'b0, "R8");

    // mixed stream against the model
    for (int n = 0; n < 600; n++) begin
      logic [3:0][NCH-1:0] r;
      for (int c = 0; c < 4; c++) r[c] = 16'($urandom & $urandom & $urandom);
      tick(r, ($urandom % 3) == 0, ADDRS[$urandom % 16], $urandom);
    end
    for (int i = 0; i < 16; i++) tick('0, 1'b0, ADDRS[i], 0);
    tick('0, 1'b0, 12'h000, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule